// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block cleans up two asynchronous external interrupt pins before they reach an interrupt controller. Each pin is brought into the clock domain through a two-flop synchronizer. It then passes through a digital noise filter that accepts a new level only after the level has stayed constant for a whole window of system clocks. Finally an edge detector emits a single-cycle event when the filtered level moves in the direction chosen for that pin.

A shared 2-bit filter-mode field applies to both pins. It either bypasses the filter or selects a hold window of 8, 16 or 32 clocks. Each pin has its own polarity bit that picks a rising or falling active edge. The filtered levels are also driven out, so that level-sensitive logic downstream can use them. Both pins idle high, and all filter state returns to that idle level on reset.

Top module: `exti_deglitch`

## Requirements
- R1: While `rstN` is low, `lvlOut` reads all ones (idle) and `evtOut` reads all zeros.
- R2: With `filtMode` = 2'b01, a change on `pinRaw[i]` made between clock edges shows on `lvlOut[i]` exactly after the 10th rising edge. This is 2 synchronizer edges plus 8 hold edges, and it is not visible after the 9th edge.
- R3: With `filtMode` = 2'b01, a pulse of 7 clocks on a pin leaves `lvlOut` and `evtOut` unchanged. A pulse of 8 clocks is passed.
- R4: A return of the synchronized input to the current filtered level, even for one clock, restarts the hold count. Two 5- and 7-clock low runs split by a one-clock high produce no event, while 5 and 8 produce one event.
- R5: `filtMode` = 2'b10 sets a hold window of 16 clocks and 2'b11 sets 32 clocks. A pulse one clock shorter than the window is removed, and a pulse equal to the window is passed.
- R6: `filtMode` = 2'b00 bypasses the filter. `lvlOut[i]` equals `pinRaw[i]` as it was sampled three rising edges earlier, and a one-clock pulse is passed.
- R7: When `edgeRise[i]` = 1, events occur only on 0-to-1 changes of `lvlOut[i]`. When it is 0, events occur only on 1-to-0 changes. Each event lasts one clock and is asserted in the same cycle in which `lvlOut[i]` takes its new value.
- R8: The two channels are independent. Activity on one pin never produces a level change or an event on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinRaw | input | NUM_IN | Raw asynchronous interrupt pins |
| filtMode | input | 2 | 00 bypass, 01 8-clock, 10 16-clock, 11 32-clock hold window |
| edgeRise | input | NUM_IN | Per-pin active edge: 1 rising, 0 falling |
| lvlOut | output | NUM_IN | Filtered pin levels |
| evtOut | output | NUM_IN | One-cycle edge event per accepted edge |

## Verification
The hardest state to reach from the ports is a hold counter that has advanced part of the way and is then reset by a one-clock bounce. From outside, this looks the same as a counter that never started. The stimulus builds low runs of 5 and 7 clocks around a single high clock, so their total exceeds the window while no single run fills it. It then repeats the pattern with a final run of exactly 8 clocks to show that the count restarted from zero and did not carry over. Pulse widths one below and exactly at each window sit at the threshold on both polarities, and the exact latency is pinned by sampling one edge before and one edge after the expected change.

// File: rtl/exti_pkg.sv
package exti_pkg;

  // Filter mode encoding shared by control and checker
  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_MID   = 2'b10,
    MODE_LONG  = 2'b11
  } fltMode_e;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic takeLvl;
  } fltStrb_t;

endpackage

// File: rtl/exti_ctrl.sv
module exti_ctrl
  import exti_pkg::*;
#(
  parameter int NUM_IN   = 2,
  parameter int BASE_LEN = 8,
  parameter int CW       = 6
) (
  input  logic [1:0]            filtMode,
  input  logic [NUM_IN-1:0]     syncLvl,
  input  logic [NUM_IN-1:0]     filtLvl,
  input  logic [NUM_IN-1:0]     cntHit,
  output logic [CW-1:0]         holdLast,
  output fltStrb_t [NUM_IN-1:0] strb
);

  localparam logic [CW-1:0] LAST_SHORT = CW'(BASE_LEN - 1);
  localparam logic [CW-1:0] LAST_MID   = CW'(2 * BASE_LEN - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(4 * BASE_LEN - 1);

  fltMode_e modeSel;
  logic     bypass;

  assign modeSel = fltMode_e'(filtMode);
  assign bypass  = (modeSel == MODE_PASS);

  // Last count value of the hold window for the selected mode
  always_comb begin
    case (modeSel)
      MODE_SHORT: holdLast = LAST_SHORT;
      MODE_MID:   holdLast = LAST_MID;
      MODE_LONG:  holdLast = LAST_LONG;
      default:    holdLast = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
    always_comb begin
      strb[i] = '0;
      if (bypass) begin
        strb[i].clrCnt  = 1'b1;
        strb[i].takeLvl = (syncLvl[i] != filtLvl[i]);
      end else if (syncLvl[i] == filtLvl[i]) begin
        // bounce back or steady: restart the window
        strb[i].clrCnt = 1'b1;
      end else if (cntHit[i]) begin
        strb[i].takeLvl = 1'b1;
        strb[i].clrCnt  = 1'b1;
      end else begin
        strb[i].incCnt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/exti_dp.sv
module exti_dp
  import exti_pkg::*;
#(
  parameter int                NUM_IN   = 2,
  parameter int                CW       = 6,
  parameter logic [NUM_IN-1:0] IDLE_LVL = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_IN-1:0]     pinRaw,
  input  logic [NUM_IN-1:0]     edgeRise,
  input  fltStrb_t [NUM_IN-1:0] strb,
  input  logic [CW-1:0]         holdLast,
  output logic [NUM_IN-1:0]     syncLvl,
  output logic [NUM_IN-1:0]     filtLvl,
  output logic [NUM_IN-1:0]     cntHit,
  output logic [NUM_IN-1:0]     evtOut
);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
    logic          metaQ;
    logic          syncQ;
    logic [CW-1:0] holdCnt;
    logic          filtQ;
    logic          filtD;

    // Two-flop synchronizer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        metaQ <= IDLE_LVL[i];
        syncQ <= IDLE_LVL[i];
      end else begin
        metaQ <= pinRaw[i];
        syncQ <= metaQ;
      end
    end

    // Hold counter
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdCnt <= '0;
      end else if (strb[i].clrCnt) begin
        holdCnt <= '0;
      end else if (strb[i].incCnt) begin
        holdCnt <= holdCnt + 1'b1;
      end
    end

    // Filtered level and its delayed copy
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        filtQ <= IDLE_LVL[i];
        filtD <= IDLE_LVL[i];
      end else begin
        if (strb[i].takeLvl) filtQ <= syncQ;
        filtD <= filtQ;
      end
    end

    assign syncLvl[i] = syncQ;
    assign filtLvl[i] = filtQ;
    assign cntHit[i]  = (holdCnt >= holdLast);
    assign evtOut[i]  = edgeRise[i] ? (filtQ & ~filtD) : (~filtQ & filtD);
  end

endmodule

// File: rtl/exti_deglitch.sv
module exti_deglitch
  import exti_pkg::*;
#(
  parameter int                NUM_IN   = 2,
  parameter int                BASE_LEN = 8,
  parameter logic [NUM_IN-1:0] IDLE_LVL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pinRaw,
  input  logic [1:0]        filtMode,
  input  logic [NUM_IN-1:0] edgeRise,
  output logic [NUM_IN-1:0] lvlOut,
  output logic [NUM_IN-1:0] evtOut
);

  localparam int CW = $clog2(4 * BASE_LEN + 1);

  fltStrb_t [NUM_IN-1:0] strb;
  logic [NUM_IN-1:0]     syncLvl;
  logic [NUM_IN-1:0]     filtLvl;
  logic [NUM_IN-1:0]     cntHit;
  logic [CW-1:0]         holdLast;

  exti_ctrl #(
    .NUM_IN  (NUM_IN),
    .BASE_LEN(BASE_LEN),
    .CW      (CW)
  ) u_ctrl (
    .filtMode(filtMode),
    .syncLvl (syncLvl),
    .filtLvl (filtLvl),
    .cntHit  (cntHit),
    .holdLast(holdLast),
    .strb    (strb)
  );

  exti_dp #(
    .NUM_IN  (NUM_IN),
    .CW      (CW),
    .IDLE_LVL(IDLE_LVL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinRaw  (pinRaw),
    .edgeRise(edgeRise),
    .strb    (strb),
    .holdLast(holdLast),
    .syncLvl (syncLvl),
    .filtLvl (filtLvl),
    .cntHit  (cntHit),
    .evtOut  (evtOut)
  );

  assign lvlOut = filtLvl;

endmodule

// File: rtl/exti_deglitch_chk.sv
module exti_deglitch_chk #(
  parameter int NUM_IN = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] pinRaw,
  input logic [1:0]        filtMode,
  input logic [NUM_IN-1:0] edgeRise,
  input logic [NUM_IN-1:0] lvlOut,
  input logic [NUM_IN-1:0] evtOut
);

  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rstN |-> (evtOut == '0));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    // R7
    evt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtOut[i] |=> (!evtOut[i] || (edgeRise[i] != $past(edgeRise[i]))));

    // R7
    evt_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtOut[i] |-> ((lvlOut[i] == edgeRise[i]) && (lvlOut[i] != $past(lvlOut[i]))));

    // R2
    lvl_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((sinceRst >= 3'd4) && (lvlOut[i] != $past(lvlOut[i])))
        |-> (lvlOut[i] == $past(pinRaw[i], 3)));

    // R6
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((sinceRst >= 3'd4) && ($past(filtMode) == 2'b00))
        |-> (lvlOut[i] == $past(pinRaw[i], 3)));
  end

endmodule

bind exti_deglitch exti_deglitch_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pinRaw  (pinRaw),
  .filtMode(filtMode),
  .edgeRise(edgeRise),
  .lvlOut  (lvlOut),
  .evtOut  (evtOut)
);

// File: tb/exti_deglitch_bench.sv
module exti_deglitch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN     = 2;
  localparam int SETTLE     = 60;

  typedef struct packed {
    logic       ch;
    logic [1:0] mode;
    logic       rise;
    logic [7:0] width;
    logic [1:0] expEvt;
    logic       expLow;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 1'b0, 8'd7,  2'd0, 1'b0},  // R3 short rejected
    '{1'b0, 2'd1, 1'b0, 8'd8,  2'd1, 1'b1},  // R3 window passes
    '{1'b0, 2'd1, 1'b1, 8'd7,  2'd0, 1'b0},  // R3 R7
    '{1'b0, 2'd1, 1'b1, 8'd8,  2'd1, 1'b1},  // R7 rising event only
    '{1'b0, 2'd2, 1'b0, 8'd15, 2'd0, 1'b0},  // R5
    '{1'b0, 2'd2, 1'b0, 8'd16, 2'd1, 1'b1},  // R5
    '{1'b0, 2'd3, 1'b1, 8'd31, 2'd0, 1'b0},  // R5
    '{1'b0, 2'd3, 1'b1, 8'd32, 2'd1, 1'b1},  // R5
    '{1'b0, 2'd0, 1'b0, 8'd1,  2'd1, 1'b1},  // R6
    '{1'b0, 2'd0, 1'b1, 8'd1,  2'd1, 1'b1},  // R6
    '{1'b1, 2'd1, 1'b0, 8'd7,  2'd0, 1'b0},  // R8 channel 1
    '{1'b1, 2'd1, 1'b1, 8'd8,  2'd1, 1'b1},  // R8
    '{1'b1, 2'd0, 1'b0, 8'd1,  2'd1, 1'b1}   // R8 R6
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_IN-1:0] pinRaw = '1;
  logic [1:0]        filtMode = 2'b01;
  logic [NUM_IN-1:0] edgeRise = '0;
  logic [NUM_IN-1:0] lvlOut;
  logic [NUM_IN-1:0] evtOut;

  int errors = 0;
  int checks = 0;
  int evtCnt [NUM_IN];
  bit lowSeen [NUM_IN];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exti_deglitch u_exti_deglitch (
    .clk     (clk),
    .rstN    (rstN),
    .pinRaw  (pinRaw),
    .filtMode(filtMode),
    .edgeRise(edgeRise),
    .lvlOut  (lvlOut),
    .evtOut  (evtOut)
  );

  always @(negedge clk) begin
    for (int c = 0; c < NUM_IN; c++) begin
      if (evtOut[c]) evtCnt[c] = evtCnt[c] + 1;
      if (!lvlOut[c]) lowSeen[c] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(posedge clk);
    for (int c = 0; c < NUM_IN; c++) begin
      evtCnt[c]  = 0;
      lowSeen[c] = 1'b0;
    end
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic lowRun(input int ch, input int len);
    pinRaw[ch] = 1'b0;
    waitNeg(len);
    pinRaw[ch] = 1'b1;
  endtask

  task automatic runVec(input vec_t v);
    int    oth;
    string tag;
    oth = (v.ch == 1'b0) ? 1 : 0;
    tag = (v.mode == 2'd0) ? "R6" : (v.mode == 2'd1) ? "R3" : "R5";
    @(negedge clk);
    filtMode = v.mode;
    edgeRise = '0;
    edgeRise[v.ch] = v.rise;
    waitNeg(4);
    clearMon();
    @(negedge clk);
    lowRun(int'(v.ch), int'(v.width));
    waitNeg(SETTLE);
    check(evtCnt[v.ch] == int'(v.expEvt), tag, evtCnt[v.ch], int'(v.expEvt));
    // R7: the level passes regardless of the chosen polarity
    check(lowSeen[v.ch] == v.expLow, "R7 level", int'(lowSeen[v.ch]), int'(v.expLow));
    check(evtCnt[oth] == 0 && !lowSeen[oth], "R8", evtCnt[oth], 0);
    check(lvlOut == 2'b11, "R3 idle after", int'(lvlOut), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    waitNeg(3);
    check(lvlOut == 2'b11, "R1 lvl", int'(lvlOut), 3);
    check(evtOut == 2'b00, "R1 evt", int'(evtOut), 0);
    rstN = 1'b1;
    waitNeg(4);
    check(lvlOut == 2'b11 && evtOut == 2'b00, "R1 after release", int'({lvlOut, evtOut}), 12);

    // Table walk: R3 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) runVec(VECS[v]);

    // R2 exact latency, falling polarity on channel 0
    filtMode = 2'b01;
    edgeRise = 2'b00;
    waitNeg(4);
    pinRaw[0] = 1'b0;
    waitNeg(9);
    check(lvlOut[0] == 1'b1, "R2 not before edge 10", int'(lvlOut[0]), 1);
    waitNeg(1);
    check(lvlOut[0] == 1'b0, "R2 at edge 10", int'(lvlOut[0]), 0);
    check(evtOut[0] == 1'b1, "R7 event with level", int'(evtOut[0]), 1);
    waitNeg(1);
    check(evtOut[0] == 1'b0, "R7 one cycle", int'(evtOut[0]), 0);
    pinRaw[0] = 1'b1;
    waitNeg(SETTLE);

    // R6 bypass latency
    filtMode = 2'b00;
    waitNeg(4);
    pinRaw[1] = 1'b0;
    waitNeg(2);
    check(lvlOut[1] == 1'b1, "R6 not before edge 3", int'(lvlOut[1]), 1);
    waitNeg(1);
    check(lvlOut[1] == 1'b0, "R6 at edge 3", int'(lvlOut[1]), 0);
    pinRaw[1] = 1'b1;
    waitNeg(10);

    // R4 bounce restarts the count
    filtMode = 2'b01;
    edgeRise = 2'b00;
    waitNeg(4);
    clearMon();
    @(negedge clk);
    lowRun(0, 5);
    waitNeg(1);
    lowRun(0, 7);
    waitNeg(SETTLE);
    check(evtCnt[0] == 0 && !lowSeen[0], "R4 split runs rejected", evtCnt[0], 0);
    clearMon();
    @(negedge clk);
    lowRun(0, 5);
    waitNeg(1);
    lowRun(0, 8);
    waitNeg(SETTLE);
    check(evtCnt[0] == 1, "R4 full run after bounce", evtCnt[0], 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule